// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table held in memory. A request carries the virtual address, the base address of the first-level table and one enable bit. The enable bit decides whether first-level entries that point at fine tables are walked or treated as faults. The walker reads one first-level word. It then either stops at a section mapping or a fault, or it reads one second-level word. That second word describes a large, small or tiny page, or a fault.

The walker has one read port. The port carries a single-cycle read request with a word address and accepts the returned word when read-valid is high, after any number of cycles. When the walk completes, a one-cycle done pulse marks the result. The result holds the physical address, a page-kind code, the cacheable/bufferable pair, the four-bit domain, the permission field and a fault flag. These outputs stay unchanged until the next walk completes. Only one walk is in progress at a time.

Controller states: IDLE (ready for a request), L1_ISSUE (first read requested), L1_WAIT (waiting for the first word), L2_ISSUE (second read requested), L2_WAIT (waiting for the second word) and FINISH (done pulse). Transitions:
- IDLE→L1_ISSUE on an accepted request.
- L1_ISSUE→L1_WAIT always.
- L1_WAIT→FINISH on a first word that is a section or a fault.
- L1_WAIT→L2_ISSUE on a first word that points at a table.
- L2_ISSUE→L2_WAIT always.
- L2_WAIT→FINISH on the second word.
- FINISH→IDLE always.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only in IDLE. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the next cycle. `done` is high for exactly one cycle per walk.
- R2: The first read, requested the cycle after acceptance, goes to {table_base[31:14], vaddr[31:20], 2'b00}.
- R3: When the first word has bits [1:0] = 00, the walk ends after that single read. `fault` is 1, and `phys_addr`, `page_kind`, `cache_bits`, `domain` and `perm` are all 0.
- R4: When the first word has bits [1:0] = 10 (section), no second read is made. The results are phys_addr = {word[31:20], vaddr[19:0]}, cache_bits = word[3:2], perm = {6'b0, word[11:10]}, page_kind = 0 and fault = 0.
- R5: When the first word has bits [1:0] = 01 (coarse table), the second read goes to {word[31:10], vaddr[19:12], 2'b00}.
- R6: When the first word has bits [1:0] = 11 (fine table) and `req_tiny_en` = 1, the second read goes to {word[31:12], vaddr[19:10], 2'b00}. When `req_tiny_en` = 0, that word ends the walk as a fault with the R3 zero results and no second read.
- R7: When the second word has bits [1:0] = 00, the walk ends as a fault with the R3 zero results.
- R8: When the second word has bits [1:0] = 01 (large page), the results are phys_addr = {word[31:16], vaddr[15:0]}, perm = word[11:4] and page_kind = 1.
- R9: When the second word has bits [1:0] = 10 (small page), the results are phys_addr = {word[31:12], vaddr[11:0]}, perm = word[11:4] and page_kind = 2.
- R10: When the second word has bits [1:0] = 11 (tiny page), the results are phys_addr = {word[31:10], vaddr[9:0]}, perm = {6'b0, word[5:4]} and page_kind = 3. For every non-faulting second-level page, cache_bits = second word [3:2].
- R11: On every non-faulting walk, `domain` equals first word bits [8:5], whatever the first-level type.
- R12: At most one read is requested per issue state, and `mem_rd_req` is never high in two consecutive cycles. Read data is waited for over any latency. A `mem_rd_valid` pulse while no read is outstanding has no effect.
- R13: All result outputs keep their values from one done pulse until the next. They change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_table_base | input | 32 | First-level table base (bits [31:14] used) |
| req_tiny_en | input | 1 | Allow fine-table first-level entries |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_addr | output | 32 | Word address of the read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Returned descriptor word |
| done | output | 1 | One-cycle walk-complete pulse |
| fault | output | 1 | Walk ended in a translation fault |
| page_kind | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| phys_addr | output | 32 | Translated physical address |
| cache_bits | output | 2 | Cacheable/bufferable pair |
| domain | output | 4 | Domain number |
| perm | output | 8 | Access-permission field, zero-extended |

## Verification
The first read request appears one cycle after the accepting edge. A second read request appears one cycle after the edge that takes the first word. `done`, together with the new results, appears one cycle after the edge that takes the final word. The bench's memory model answers a read 1 to 3 cycles after it sees the request. The bench waits for `done` at falling edges and checks the results in that same cycle. It then checks for three further cycles, during which it also sends a stray read-valid pulse, that nothing has moved. The sweep covers every combination of first-level type, second-level type, tiny-page enable and latency, using two address patterns.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int WORD_W  = 32;
    localparam int DOM_W   = 4;
    localparam int PERM_W  = 8;
    localparam int CB_W    = 2;
    localparam int TYPE_W  = 2;
    localparam int BASE_LO = 14;               // table base alignment
    localparam int SEC_W   = 20;               // section offset width
    localparam int LRG_W   = 16;               // large page offset width
    localparam int SML_W   = 12;               // small page offset width
    localparam int TNY_W   = 10;               // tiny page offset width

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_ISSUE,
        ST_L1_WAIT,
        ST_L2_ISSUE,
        ST_L2_WAIT,
        ST_FINISH
    } walk_state_e;

    typedef enum logic [TYPE_W-1:0] {
        L1_FAULT   = 2'b00,
        L1_COARSE  = 2'b01,
        L1_SECTION = 2'b10,
        L1_FINE    = 2'b11
    } l1_kind_e;

    typedef enum logic [TYPE_W-1:0] {
        L2_FAULT = 2'b00,
        L2_LARGE = 2'b01,
        L2_SMALL = 2'b10,
        L2_TINY  = 2'b11
    } l2_kind_e;

    typedef enum logic [1:0] {
        PG_SECTION = 2'd0,
        PG_LARGE   = 2'd1,
        PG_SMALL   = 2'd2,
        PG_TINY    = 2'd3
    } page_kind_e;

    typedef struct packed {
        logic              fault;
        page_kind_e        kind;
        logic [CB_W-1:0]   cb;
        logic [DOM_W-1:0]  domain;
        logic [PERM_W-1:0] perm;
        logic [WORD_W-1:0] pa;
    } walk_result_t;

endpackage

// File: rtl/pt_l1_decode.sv
module pt_l1_decode
    import pt_walker_pkg::*;
(
    input  logic [WORD_W-1:0] desc,
    input  logic [SEC_W-1:0]  va_low,
    input  logic              tiny_en,
    output logic              terminal,
    output walk_result_t      term_res,
    output logic [WORD_W-1:0] l2_addr
);

    logic unused_l1_bits;
    assign unused_l1_bits = ^{desc[9], desc[4]};

    always_comb begin
        term_res = '0;
        terminal = 1'b1;
        l2_addr  = '0;
        unique case (l1_kind_e'(desc[TYPE_W-1:0]))
            L1_FAULT: begin
                term_res.fault = 1'b1;
            end
            L1_SECTION: begin
                term_res.kind   = PG_SECTION;
                term_res.pa     = {desc[WORD_W-1:SEC_W], va_low};
                term_res.cb     = desc[3:2];
                term_res.domain = desc[8:5];
                term_res.perm   = {{(PERM_W-2){1'b0}}, desc[11:10]};
            end
            L1_COARSE: begin
                terminal = 1'b0;
                l2_addr  = {desc[WORD_W-1:10], va_low[SEC_W-1:12], 2'b00};
            end
            L1_FINE: begin
                if (tiny_en) begin
                    terminal = 1'b0;
                    l2_addr  = {desc[WORD_W-1:12], va_low[SEC_W-1:10], 2'b00};
                end else begin
                    term_res.fault = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/pt_l2_decode.sv
module pt_l2_decode
    import pt_walker_pkg::*;
(
    input  logic [WORD_W-1:0] desc,
    input  logic [LRG_W-1:0]  va_low,
    input  logic [DOM_W-1:0]  l1_domain,
    output walk_result_t      res
);

    always_comb begin
        res        = '0;
        res.cb     = desc[3:2];
        res.domain = l1_domain;
        unique case (l2_kind_e'(desc[TYPE_W-1:0]))
            L2_FAULT: begin
                res = '0;
                res.fault = 1'b1;
            end
            L2_LARGE: begin
                res.kind = PG_LARGE;
                res.pa   = {desc[WORD_W-1:LRG_W], va_low};
                res.perm = desc[11:4];
            end
            L2_SMALL: begin
                res.kind = PG_SMALL;
                res.pa   = {desc[WORD_W-1:SML_W], va_low[SML_W-1:0]};
                res.perm = desc[11:4];
            end
            L2_TINY: begin
                res.kind = PG_TINY;
                res.pa   = {desc[WORD_W-1:TNY_W], va_low[TNY_W-1:0]};
                res.perm = {{(PERM_W-2){1'b0}}, desc[5:4]};
            end
        endcase
    end

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
    import pt_walker_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic rd_valid,
    input  logic l1_terminal,
    output logic req_ready,
    output logic rd_req,
    output logic done,
    output logic accept,
    output logic l1_take,
    output logic l2_take
);

    walk_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_L1_ISSUE;
            ST_L1_ISSUE: state_d = ST_L1_WAIT;
            ST_L1_WAIT:  if (rd_valid) state_d = l1_terminal ? ST_FINISH : ST_L2_ISSUE;
            ST_L2_ISSUE: state_d = ST_L2_WAIT;
            ST_L2_WAIT:  if (rd_valid) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rd_req    = (state_q == ST_L1_ISSUE) || (state_q == ST_L2_ISSUE);
        done      = (state_q == ST_FINISH);
        accept    = req_ready && req_valid;
        l1_take   = (state_q == ST_L1_WAIT) && rd_valid;
        l2_take   = (state_q == ST_L2_WAIT) && rd_valid;
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [31:0] req_table_base,
    input  logic        req_tiny_en,
    output logic        mem_rd_req,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_valid,
    input  logic [31:0] mem_rd_data,
    output logic        done,
    output logic        fault,
    output logic [1:0]  page_kind,
    output logic [31:0] phys_addr,
    output logic [1:0]  cache_bits,
    output logic [3:0]  domain,
    output logic [7:0]  perm
);

    logic              accept, l1_take, l2_take;
    logic              l1_terminal;
    logic [SEC_W-1:0]  va_q;
    logic              tiny_q;
    logic [WORD_W-1:0] addr_q;
    logic [DOM_W-1:0]  dom_q;
    walk_result_t      res_q, l1_res, l2_res;
    logic [WORD_W-1:0] l2_addr;

    logic unused_base;
    assign unused_base = ^req_table_base[BASE_LO-1:0];

    pt_walk_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .rd_valid   (mem_rd_valid),
        .l1_terminal(l1_terminal),
        .req_ready  (req_ready),
        .rd_req     (mem_rd_req),
        .done       (done),
        .accept     (accept),
        .l1_take    (l1_take),
        .l2_take    (l2_take)
    );

    pt_l1_decode u_l1 (
        .desc    (mem_rd_data),
        .va_low  (va_q),
        .tiny_en (tiny_q),
        .terminal(l1_terminal),
        .term_res(l1_res),
        .l2_addr (l2_addr)
    );

    pt_l2_decode u_l2 (
        .desc     (mem_rd_data),
        .va_low   (va_q[LRG_W-1:0]),
        .l1_domain(dom_q),
        .res      (l2_res)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            tiny_q <= 1'b0;
            addr_q <= '0;
            dom_q  <= '0;
            res_q  <= '0;
        end else begin
            if (accept) begin
                va_q   <= req_vaddr[SEC_W-1:0];
                tiny_q <= req_tiny_en;
                addr_q <= {req_table_base[WORD_W-1:BASE_LO],
                           req_vaddr[WORD_W-1:SEC_W], 2'b00};
            end
            if (l1_take) begin
                dom_q <= mem_rd_data[8:5];
                if (l1_terminal) res_q  <= l1_res;
                else             addr_q <= l2_addr;
            end
            if (l2_take) res_q <= l2_res;
        end
    end

    assign mem_rd_addr = addr_q;
    assign fault       = res_q.fault;
    assign page_kind   = res_q.kind;
    assign phys_addr   = res_q.pa;
    assign cache_bits  = res_q.cb;
    assign domain      = res_q.domain;
    assign perm        = res_q.perm;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_rd_req,
    input logic [31:0] mem_rd_addr,
    input logic        done,
    input logic        fault,
    input logic [1:0]  page_kind,
    input logic [31:0] phys_addr,
    input logic [1:0]  cache_bits,
    input logic [3:0]  domain,
    input logic [7:0]  perm
);

    logic [1:0] rd_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                      rd_cnt <= '0;
        else if (req_valid && req_ready) rd_cnt <= '0;
        else if (mem_rd_req && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R1
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);                          // R1
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));                       // R2
    AST_FAULT_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (phys_addr == 32'd0 && page_kind == 2'd0 &&
                             cache_bits == 2'd0 && domain == 4'd0 && perm == 8'd0)); // R3
    AST_SECTION_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && page_kind == 2'd0) |-> (rd_cnt == 2'd1));       // R4
    AST_PAGE_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && page_kind != 2'd0) |-> (rd_cnt == 2'd2));       // R8
    AST_TINY_PERM_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && page_kind == 2'd3) |-> (perm[7:2] == 6'd0));    // R10
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);                                       // R12
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({fault, page_kind, phys_addr, cache_bits, domain, perm}) |-> done); // R13

endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .mem_rd_req (mem_rd_req),
    .mem_rd_addr(mem_rd_addr),
    .done       (done),
    .fault      (fault),
    .page_kind  (page_kind),
    .phys_addr  (phys_addr),
    .cache_bits (cache_bits),
    .domain     (domain),
    .perm       (perm)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_table_base = '0;
    logic        req_tiny_en = 1'b0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        done, fault;
    logic [1:0]  page_kind, cache_bits;
    logic [31:0] phys_addr;
    logic [3:0]  domain;
    logic [7:0]  perm;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [31:0] l1_word, l2_word;
    int          lat_cfg = 0;
    int          pend = 0;
    int          nreads = 0;
    logic [31:0] rec_addr [0:3];
    logic        stray = 1'b0;

    always #2.5 clk = ~clk;

    pt_walker uut (.*);

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            summary_and_end();
        end
    end

    // memory model: answers lat_cfg+1 cycles after it sees a request
    always @(negedge clk) begin
        mem_rd_valid = 1'b0;
        if (stray) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = 32'h0000_0002;
            stray = 1'b0;
        end
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = (nreads == 1) ? l1_word : l2_word;
            end
        end
        if (mem_rd_req) begin
            if (nreads < 4) rec_addr[nreads] = mem_rd_addr;
            nreads++;
            pend = lat_cfg + 1;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [48:0] pack_res();
        return {fault, page_kind, cache_bits, domain, perm, phys_addr};
    endfunction

    task automatic run_walk(input logic [31:0] va, input logic [31:0] base,
                            input logic tiny, input logic [31:0] d1,
                            input logic [31:0] d2, input int lat);
        logic        e_fault;
        logic [1:0]  e_kind, e_cb;
        logic [3:0]  e_dom;
        logic [7:0]  e_perm;
        logic [31:0] e_pa, e_a1, e_a2;
        int          e_reads;
        string       tag;
        logic [48:0] snap;
        int          w;

        e_fault = 1'b0; e_kind = 2'd0; e_cb = 2'd0; e_dom = 4'd0;
        e_perm = 8'd0; e_pa = 32'd0; e_a2 = 32'd0; e_reads = 1;
        e_a1 = {base[31:14], va[31:20], 2'b00};
        if (d1[1:0] == 2'b00) begin
            e_fault = 1'b1; tag = "R3";
        end else if (d1[1:0] == 2'b11 && !tiny) begin
            e_fault = 1'b1; tag = "R6";
        end else if (d1[1:0] == 2'b10) begin
            tag = "R4";
            e_pa = {d1[31:20], va[19:0]}; e_cb = d1[3:2];
            e_perm = {6'd0, d1[11:10]}; e_dom = d1[8:5];
        end else begin
            e_reads = 2;
            e_a2 = (d1[1:0] == 2'b01) ? {d1[31:10], va[19:12], 2'b00}
                                      : {d1[31:12], va[19:10], 2'b00};
            case (d2[1:0])
                2'b00: begin e_fault = 1'b1; tag = "R7"; end
                2'b01: begin tag = "R8"; e_kind = 2'd1;
                             e_pa = {d2[31:16], va[15:0]}; e_perm = d2[11:4]; end
                2'b10: begin tag = "R9"; e_kind = 2'd2;
                             e_pa = {d2[31:12], va[11:0]}; e_perm = d2[11:4]; end
                default: begin tag = "R10"; e_kind = 2'd3;
                             e_pa = {d2[31:10], va[9:0]}; e_perm = {6'd0, d2[5:4]}; end
            endcase
            if (!e_fault) begin e_cb = d2[3:2]; e_dom = d1[8:5]; end
        end

        l1_word = d1; l2_word = d2; lat_cfg = lat;
        @(negedge clk);
        nreads = 0;
        check("R1 ready in idle", {63'd0, req_ready}, 64'd1);
        req_vaddr = va; req_table_base = base; req_tiny_en = tiny; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = ~va; req_table_base = ~base; req_tiny_en = ~tiny;
        check("R1 busy after accept", {63'd0, req_ready}, 64'd0);
        w = 0;
        while (!done && w < 100) begin
            @(negedge clk);
            w++;
        end
        check("R1 done seen", {63'd0, done}, 64'd1);
        check(tag, {15'd0, pack_res()},
              {15'd0, e_fault, e_kind, e_cb, e_dom, e_perm, e_pa});
        if (!e_fault) check("R11 domain", {60'd0, domain}, {60'd0, e_dom});
        check("R2 first address", {32'd0, rec_addr[0]}, {32'd0, e_a1});
        check("R12 read count", nreads, e_reads);
        if (e_reads == 2)
            check((d1[1:0] == 2'b01) ? "R5 coarse address" : "R6 fine address",
                  {32'd0, rec_addr[1]}, {32'd0, e_a2});
        snap = pack_res();
        stray = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 done pulse ended", {63'd0, done}, 64'd0);
        check("R13 R12 results held through stray valid", {15'd0, pack_res()}, {15'd0, snap});
    endtask

    initial begin
        rec_addr[0] = '0; rec_addr[1] = '0; rec_addr[2] = '0; rec_addr[3] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ready", {63'd0, req_ready}, 64'd1);
        check("R1 reset done", {63'd0, done}, 64'd0);
        check("R12 reset no read", {63'd0, mem_rd_req}, 64'd0);
        check("R13 reset results", {15'd0, pack_res()}, 64'd0);
        for (int p = 0; p < 2; p++) begin
            for (int t1 = 0; t1 < 4; t1++) begin
                for (int t2 = 0; t2 < 4; t2++) begin
                    for (int tn = 0; tn < 2; tn++) begin
                        for (int lat = 0; lat < 3; lat++) begin
                            logic [31:0] va, base, d1, d2;
                            va   = (p == 0) ? 32'h8765_4321 : 32'h1ABC_DEF9;
                            va   = va ^ (32'(t1 * 7 + t2 * 3 + lat) << 11);
                            base = 32'hC003_7FFF ^ 32'(p << 20);
                            d1   = 32'hA5C3_9E70 ^ 32'((t2 * 5 + lat + p * 9) * 32'h0104_0321);
                            d2   = 32'h5E2B_71D0 ^ 32'((t1 * 3 + tn + p * 11) * 32'h0213_0517);
                            d1[1:0] = 2'(t1);
                            d2[1:0] = 2'(t2);
                            run_walk(va, base, tn[0], d1, d2, lat);
                        end
                    end
                end
            end
        end
        summary_and_end();
    end

endmodule